// File: doc/BRIEF.md
# Paged Program Counter

This block generates the instruction fetch address for a small 4-bit core whose program store has grown to 256 bytes. The fetch address is 8 bits. Sequential execution simply increments all 8 bits. A taken jump forms the new address from two halves. The upper half comes from a 4-bit page register. The lower half comes from the core's adder output, which is the jump's source value plus its immediate.

The page register is loaded by an opcode that used to be the conditional jump through register B. That opcode now writes B plus the immediate into the page register. The load has no direct effect on the fetch address. The page it stores is used by the next taken jump and by every later one until the register is reloaded. Data memory is not touched by this block and stays at 16 words. The program store is read-only from the core's side.

The core's decoder drives one strobe per relevant instruction, together with a `step` qualifier that marks the cycle in which an instruction retires. The registered address goes straight to the program ROM.

Top module: `pc_page_unit`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0x00 and the page register to 0. A jump taken right after reset therefore lands in page 0.
- R2: On a retiring step with no jump taken, the 8-bit fetch address increments by one. It carries from the low nibble into the high nibble (0x0F goes to 0x10) and wraps from 0xFF to 0x00.
- R3: On a retiring step with the unconditional jump strobe, the fetch address becomes {page register, jump target}. The page register supplies bits 7:4 and the 4-bit adder result supplies bits 3:0.
- R4: On a retiring step with the conditional-jump strobe, the jump is taken only when the carry input is 0. When carry is 1, the address increments as in R2.
- R5: On a retiring step with the page-load strobe, the page register takes (B + immediate) mod 16. In that same step the fetch address increments as in R2.
- R6: While `step` is low, the fetch address and the page register both hold, whatever the strobes show.
- R7: A loaded page persists and is used by every later taken jump until the next page load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Instruction retires this cycle |
| op_jmp | input | 1 | Decoded unconditional jump |
| op_jnc | input | 1 | Decoded jump-if-carry-clear |
| op_page | input | 1 | Decoded page-register load |
| carry | input | 1 | Carry flag from the core |
| b_val | input | 4 | Register B value |
| imm | input | 4 | Instruction immediate |
| tgt_sum | input | 4 | Adder result used as jump offset in page |
| rom_addr | output | 8 | Registered program ROM address |

## Verification
Every result lands exactly one clock edge after the retiring step that causes it. This holds for increments, jumps and page loads alike. A page load is observed through the address produced by the next taken jump. For each step it drives, the bench pushes the address expected after the next rising edge into a queue. The monitor pops and compares that address at the following falling edge, so a sample never coincides with the edge that updates the register.

// File: rtl/pcpg_pkg.sv
package pcpg_pkg;
  typedef struct packed {
    logic jmp;
    logic jnc;
    logic page;
  } strobe_t;
endpackage

// File: rtl/pcpg_branch.sv
module pcpg_branch
  import pcpg_pkg::*;
(
  input  logic    step,
  input  strobe_t strb,
  input  logic    carry,
  output logic    taken
);
  always_comb begin
    taken = 1'b0;
    if (step) begin
      if (strb.jmp)
        taken = 1'b1;
      else if (strb.jnc && !carry)
        taken = 1'b1;
    end
  end
endmodule

// File: rtl/pcpg_page_reg.sv
module pcpg_page_reg #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] b_val,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] page_q
);
  logic [DATA_W-1:0] sum_w;

  assign sum_w = b_val + imm;

  always_ff @(posedge clk) begin
    if (rst)
      page_q <= '0;
    else if (load)
      page_q <= sum_w;
  end

  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> page_q == DATA_W'($past(b_val) + $past(imm))); // R5
  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(page_q)); // R7
endmodule

// File: rtl/pcpg_counter.sv
module pcpg_counter #(
  parameter int DATA_W = 4,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              taken,
  input  logic [DATA_W-1:0] page,
  input  logic [DATA_W-1:0] target,
  output logic [ADDR_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= '0;
    else if (step) begin
      if (taken)
        pc_q <= {page, target};
      else
        pc_q <= pc_q + ADDR_W'(1);
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pc_q)); // R6
  AST_PC_INCR: assert property (@(posedge clk) disable iff (rst)
    (step && !taken) |=> pc_q == $past(pc_q) + ADDR_W'(1)); // R2
  AST_PC_JUMP: assert property (@(posedge clk) disable iff (rst)
    (step && taken) |=> pc_q == {$past(page), $past(target)}); // R3
endmodule

// File: rtl/pc_page_unit.sv
module pc_page_unit
  import pcpg_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              op_jmp,
  input  logic              op_jnc,
  input  logic              op_page,
  input  logic              carry,
  input  logic [DATA_W-1:0] b_val,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] tgt_sum,
  output logic [ADDR_W-1:0] rom_addr
);
  strobe_t           strb;
  logic              taken;
  logic [DATA_W-1:0] page_q;

  assign strb = '{jmp: op_jmp, jnc: op_jnc, page: op_page};

  pcpg_branch u_branch (
    .step  (step),
    .strb  (strb),
    .carry (carry),
    .taken (taken)
  );

  pcpg_page_reg #(.DATA_W(DATA_W)) u_page (
    .clk    (clk),
    .rst    (rst),
    .load   (step && strb.page),
    .b_val  (b_val),
    .imm    (imm),
    .page_q (page_q)
  );

  pcpg_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .taken  (taken),
    .page   (page_q),
    .target (tgt_sum),
    .pc_q   (rom_addr)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    step |-> $onehot0({op_jmp, op_jnc, op_page})); // R3
  AST_CARRY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (step && op_jnc && carry) |=> rom_addr == $past(rom_addr) + ADDR_W'(1)); // R4
  AST_PAGE_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
    (step && op_page) |=> rom_addr == $past(rom_addr) + ADDR_W'(1)); // R5
endmodule

// File: tb/pc_page_unit_test.sv
module pc_page_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step = 1'b0, op_jmp = 1'b0, op_jnc = 1'b0, op_page = 1'b0, carry = 1'b0;
  logic [3:0] b_val = '0, imm = '0, tgt_sum = '0;
  logic [7:0] rom_addr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] addr;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] m_pc;
  logic [3:0] m_page;

  always #2.5 clk = ~clk;

  pc_page_unit uut (
    .clk(clk), .rst(rst), .step(step), .op_jmp(op_jmp), .op_jnc(op_jnc),
    .op_page(op_page), .carry(carry), .b_val(b_val), .imm(imm),
    .tgt_sum(tgt_sum), .rom_addr(rom_addr)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rom_addr=%02h expected %02h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the address due after the next edge
  task automatic drive(input logic s, input logic j, input logic jn, input logic pg,
                       input logic c, input logic [3:0] b, input logic [3:0] im,
                       input logic [3:0] t, input string tag);
    exp_t e;
    @(negedge clk); #1;
    step = s; op_jmp = j; op_jnc = jn; op_page = pg; carry = c;
    b_val = b; imm = im; tgt_sum = t;
    if (s) begin
      if (j || (jn && !c)) m_pc = {m_page, t};
      else                 m_pc = m_pc + 8'd1;
      if (pg) m_page = b + im;
    end
    e.addr = m_pc; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1'b1; step = 1'b0;
    @(negedge clk); #1;
    rst = 1'b0;
    m_pc = '0; m_page = '0;
    check(rom_addr, 8'h00, "R1 reset");
  endtask

  // monitor: compares away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(rom_addr, e.addr, e.tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: rom_addr=%02h expected run end", rom_addr);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_pc = '0; m_page = '0;
    repeat (3) @(posedge clk);
    do_reset();
    // R2: sequential count through a nibble carry
    for (int i = 0; i < 20; i++) drive(1, 0, 0, 0, 0, 4'h0, 4'h0, 4'h0, "R2 increment");
    // R6: no step, strobes ignored
    drive(0, 1, 0, 0, 0, 4'h0, 4'h0, 4'hA, "R6 hold jmp");
    drive(0, 0, 0, 1, 0, 4'h9, 4'h9, 4'h0, "R6 hold page");
    drive(0, 0, 1, 0, 0, 4'h0, 4'h0, 4'h3, "R6 hold jnc");
    drive(1, 1, 0, 0, 0, 4'h0, 4'h0, 4'h2, "R6 page unchanged");
    // R5: page load with increment
    drive(1, 0, 0, 1, 0, 4'h3, 4'h4, 4'hC, "R5 page load increments");
    drive(1, 1, 0, 0, 0, 4'h0, 4'h0, 4'h5, "R3 R7 jump into page 7");
    drive(1, 0, 1, 0, 1, 4'h0, 4'h0, 4'h1, "R4 carry set no jump");
    drive(1, 0, 1, 0, 0, 4'h0, 4'h0, 4'h9, "R4 carry clear jump");
    drive(1, 1, 0, 0, 0, 4'h0, 4'h0, 4'h0, "R7 page persists");
    // R5: modulo-16 page sum
    drive(1, 0, 0, 1, 0, 4'hF, 4'h2, 4'h0, "R5 page wrap load");
    drive(1, 1, 0, 0, 0, 4'h0, 4'h0, 4'hE, "R5 wrapped page jump");
    // R2: wrap at top of space
    drive(1, 0, 0, 1, 0, 4'hF, 4'h0, 4'h0, "R5 page F");
    drive(1, 1, 0, 0, 0, 4'h0, 4'h0, 4'hE, "R3 jump FE");
    drive(1, 0, 0, 0, 0, 4'h0, 4'h0, 4'h0, "R2 to FF");
    drive(1, 0, 0, 0, 0, 4'h0, 4'h0, 4'h0, "R2 wrap 00");
    drive(0, 0, 0, 0, 0, 4'h0, 4'h0, 4'h0, "R6 idle");
    @(negedge clk); @(negedge clk);
    // R1: reset clears page
    do_reset();
    drive(1, 1, 0, 0, 0, 4'h0, 4'h0, 4'h3, "R1 page cleared");
    drive(0, 0, 0, 0, 0, 4'h0, 4'h0, 4'h0, "R6 idle end");
    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule